// File: doc/BRIEF.md
# Monotonic Slewing Timestamp Counter

This block keeps a local time-of-day value as a seconds field and a nanoseconds field. Every clock cycle the nanoseconds field grows by a fixed increment. When it reaches the per-second limit it rolls over and carries into seconds. Until the first rising edge of the pulse-per-second input, the counter sits at zero. On that edge it takes its seconds value from the time-of-day input and starts running. After that it is never loaded again.

Offset corrections arrive on a valid/ready stream. An accepted correction becomes a pending offset. The counter works it off one nanosecond at a time, adding or removing that nanosecond once every `SLEW_N` cycles, so the value never jumps and never goes backwards. The stream applies back-pressure. `corr_ready_o` is low before the epoch is set, while the stability gate input is low, and while an earlier correction is still being worked off. A source must hold `corr_valid_i` and `corr_ofs_i` until a cycle in which both valid and ready are high.

Two capture strobes, one for ingress and one for egress, latch the counter and add a delay constant for their own path. Anomalies come out as a one-cycle event with a reason code. An over-limit correction raises a step event, a pulse-per-second edge away from the counter's own second boundary raises a glitch event, and overflow of the seconds field raises a wrap event.

Top module: `mono_slew_tod`

## Requirements
- R1: While reset is held low the outputs are as follows. `sec_o` and `ns_o` are zero, and `epoch_o` is low. `corr_ready_o`, `evt_valid_o`, `ing_vld_o` and `egr_vld_o` are low.
- R2: The first rising edge of `pps_i` sets `sec_o` to `tod_sec_i` and `ns_o` to 0, and sets `epoch_o` high. `epoch_o` then stays high, and later `pps_i` edges never reload the counter.
- R3: Once the epoch is set, `ns_o` grows by `NS_INC` each cycle when no slew is applied. It stays below `NS_PER_SEC`. A rollover past `NS_PER_SEC` subtracts `NS_PER_SEC` and adds one to `sec_o`, and raises no event.
- R4: Take a cycle in which a nonzero pending offset has waited `SLEW_N` cycles. In that cycle the increment is `NS_INC+1` when the offset is positive and `NS_INC-1` when it is negative, and the offset moves one nanosecond toward zero. Each accepted offset is fully absorbed this way.
- R5: `corr_ready_o` is high only when the epoch is set, `stable_i` is high and no offset is pending. A correction transfers only on a cycle with valid and ready both high. A correction held while ready is low has no effect.
- R6: A transferred correction whose magnitude exceeds `max_corr_i` is discarded, and the counter keeps its plain trajectory. The event output then shows code 1 (step). A magnitude equal to `max_corr_i` is accepted.
- R7: After the epoch is set, a `pps_i` rising edge that finds `ns_o` in [`GLITCH_WIN`, `NS_PER_SEC-GLITCH_WIN`) raises code 2 (glitch). Edges outside that range raise nothing, and no edge changes the counter.
- R8: A rollover while `sec_o` is all ones sets `sec_o` to zero and raises code 3 (wrap).
- R9: Take a cycle in which `ing_stb_i` (or `egr_stb_i`) is high. On the next cycle `ing_vld_o` (`egr_vld_o`) pulses. The timestamp it carries is the counter value from the strobe cycle plus `ing_dly_i` (`egr_dly_i`) nanoseconds, carried into seconds when needed. Each path uses only its own delay.
- R10: Events are registered and appear one cycle after their cause as a single `evt_valid_o` pulse with one code. Code 0 is never shown with valid. When causes coincide, glitch wins over step, and step wins over wrap.
- R11: After the epoch is set, the per-cycle advance of `ns_o` (modulo `NS_PER_SEC`) is never smaller than `NS_INC-1` and never larger than `NS_INC+1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | Pulse-per-second input, rising edge used |
| tod_sec_i | input | SEC_W | Seconds value loaded on the first pulse |
| stable_i | input | 1 | Stability gate for accepting corrections |
| corr_valid_i | input | 1 | Correction valid |
| corr_ready_o | output | 1 | Correction ready |
| corr_ofs_i | input | OFS_W | Signed offset in nanoseconds |
| max_corr_i | input | OFS_W | Largest accepted magnitude |
| sec_o | output | SEC_W | Seconds field |
| ns_o | output | NS_W | Nanoseconds field |
| epoch_o | output | 1 | Epoch has been set |
| ing_stb_i | input | 1 | Ingress capture strobe |
| ing_dly_i | input | DLY_W | Ingress delay in ns, below NS_PER_SEC |
| ing_vld_o | output | 1 | Ingress timestamp valid pulse |
| ing_sec_o | output | SEC_W | Ingress timestamp seconds |
| ing_ns_o | output | NS_W | Ingress timestamp nanoseconds |
| egr_stb_i | input | 1 | Egress capture strobe |
| egr_dly_i | input | DLY_W | Egress delay in ns, below NS_PER_SEC |
| egr_vld_o | output | 1 | Egress timestamp valid pulse |
| egr_sec_o | output | SEC_W | Egress timestamp seconds |
| egr_ns_o | output | NS_W | Egress timestamp nanoseconds |
| evt_valid_o | output | 1 | Event pulse |
| evt_code_o | output | 2 | Event reason: 1 step, 2 glitch, 3 wrap |

## Verification
The bounded-advance and monotonic properties rely on two conditions on the parameters: `NS_INC` is at least 2, and it is much smaller than `NS_PER_SEC`. The capture and carry properties rely on both delay inputs staying below `NS_PER_SEC`. The stimulus respects both conditions, using a 1000 ns second and delays of 30 and 995. It holds a correction until the handshake completes, as the back-pressure rule asks. It drives `pps_i` low for at least one cycle between pulses, so every intended edge is seen as a rising edge. It applies over-limit corrections and off-boundary pulses in the same cycle to exercise the event priority.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_STEP   = 2'd1,
    EV_GLITCH = 2'd2,
    EV_WRAP   = 2'd3
  } tsc_evt_e;
endpackage

// File: rtl/tsc_slew.sv
// Holds the pending offset and releases it one nanosecond at a time.
module tsc_slew #(
  parameter int OFS_W  = 24,
  parameter int SLEW_N = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable_i,
  input  logic                    stable_i,
  input  logic                    corr_valid_i,
  output logic                    corr_ready_o,
  input  logic signed [OFS_W-1:0] corr_ofs_i,
  input  logic        [OFS_W-1:0] max_corr_i,
  output logic signed [1:0]       adj_o,
  output logic                    step_o
);
  localparam int CNT_W = (SLEW_N > 1) ? $clog2(SLEW_N) : 1;

  logic signed [OFS_W-1:0] pend_q;
  logic        [CNT_W-1:0] cnt_q;
  logic        [OFS_W-1:0] mag;
  logic                    idle, take, over, fire;

  assign idle         = (pend_q == '0);
  assign corr_ready_o = enable_i & stable_i & idle;
  assign take         = corr_valid_i & corr_ready_o;
  assign mag          = corr_ofs_i[OFS_W-1] ? (~corr_ofs_i + 1'b1) : corr_ofs_i;
  assign over         = mag > max_corr_i;
  assign fire         = !idle && (cnt_q == CNT_W'(SLEW_N - 1));
  assign adj_o        = !fire ? 2'sd0 : (pend_q[OFS_W-1] ? -2'sd1 : 2'sd1);
  assign step_o       = take & over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      if (!over) pend_q <= corr_ofs_i;
      cnt_q <= '0;
    end else if (!idle) begin
      if (fire) begin
        cnt_q <= '0;
        if (pend_q[OFS_W-1]) pend_q <= pend_q + OFS_W'(1);
        else                 pend_q <= pend_q - OFS_W'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tsc_core.sv
// Seconds/nanoseconds counter, epoch load and boundary check of the PPS edge.
module tsc_core #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int NS_INC     = 8,
  parameter int GLITCH_WIN = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic [SEC_W-1:0]  tod_sec_i,
  input  logic signed [1:0] adj_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o,
  output logic              epoch_o,
  output logic              glitch_o,
  output logic              wrap_o
);
  localparam int SW = NS_W + 1;

  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;
  logic             epoch_q, pps_q, rise, roll;
  logic [SW-1:0]    sum, wrapped;

  assign rise     = pps_i & ~pps_q;
  assign sum      = {1'b0, ns_q} + SW'(NS_INC) + {{(SW-2){adj_i[1]}}, adj_i};
  assign roll     = sum >= SW'(NS_PER_SEC);
  assign wrapped  = sum - SW'(NS_PER_SEC);
  assign glitch_o = epoch_q & rise & (ns_q >= NS_W'(GLITCH_WIN))
                    & (ns_q < NS_W'(NS_PER_SEC - GLITCH_WIN));
  assign wrap_o   = epoch_q & roll & (&sec_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= '0;
      ns_q    <= '0;
      epoch_q <= 1'b0;
      pps_q   <= 1'b0;
    end else begin
      pps_q <= pps_i;
      if (!epoch_q) begin
        if (rise) begin
          sec_q   <= tod_sec_i;
          ns_q    <= '0;
          epoch_q <= 1'b1;
        end
      end else begin
        ns_q <= roll ? wrapped[NS_W-1:0] : sum[NS_W-1:0];
        if (roll) sec_q <= sec_q + SEC_W'(1);
      end
    end
  end

  assign sec_o   = sec_q;
  assign ns_o    = ns_q;
  assign epoch_o = epoch_q;
endmodule

// File: rtl/tsc_capture.sv
// Latches the counter on a strobe and adds the path delay.
module tsc_capture #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int DLY_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             vld_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  localparam int SW = NS_W + 1;

  logic [SW-1:0] sum, less;
  logic          carry;

  assign sum   = {1'b0, ns_i} + SW'(dly_i);
  assign carry = sum >= SW'(NS_PER_SEC);
  assign less  = sum - SW'(NS_PER_SEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      sec_o <= '0;
      ns_o  <= '0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) begin
        sec_o <= carry ? sec_i + SEC_W'(1) : sec_i;
        ns_o  <= carry ? less[NS_W-1:0] : sum[NS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mono_slew_tod.sv
module mono_slew_tod
  import tsc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int NS_INC     = 8,
  parameter int SLEW_N     = 16,
  parameter int OFS_W      = 24,
  parameter int GLITCH_WIN = 100,
  parameter int DLY_W      = 16,
  localparam int NS_W      = $clog2(NS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic [SEC_W-1:0]  tod_sec_i,
  input  logic              stable_i,
  input  logic              corr_valid_i,
  output logic              corr_ready_o,
  input  logic [OFS_W-1:0]  corr_ofs_i,
  input  logic [OFS_W-1:0]  max_corr_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o,
  output logic              epoch_o,
  input  logic              ing_stb_i,
  input  logic [DLY_W-1:0]  ing_dly_i,
  output logic              ing_vld_o,
  output logic [SEC_W-1:0]  ing_sec_o,
  output logic [NS_W-1:0]   ing_ns_o,
  input  logic              egr_stb_i,
  input  logic [DLY_W-1:0]  egr_dly_i,
  output logic              egr_vld_o,
  output logic [SEC_W-1:0]  egr_sec_o,
  output logic [NS_W-1:0]   egr_ns_o,
  output logic              evt_valid_o,
  output logic [1:0]        evt_code_o
);
  localparam int NCAP = 2;

  logic signed [1:0] adj;
  logic              step, glitch, wrap;
  tsc_evt_e          evt_q;
  logic              evt_v_q;

  logic [NCAP-1:0]  cap_stb, cap_vld;
  logic [DLY_W-1:0] cap_dly [NCAP];
  logic [SEC_W-1:0] cap_sec [NCAP];
  logic [NS_W-1:0]  cap_ns  [NCAP];

  tsc_slew #(.OFS_W(OFS_W), .SLEW_N(SLEW_N)) u_slew (
    .clk(clk), .rst_n(rst_n), .enable_i(epoch_o), .stable_i(stable_i),
    .corr_valid_i(corr_valid_i), .corr_ready_o(corr_ready_o),
    .corr_ofs_i(corr_ofs_i), .max_corr_i(max_corr_i),
    .adj_o(adj), .step_o(step)
  );

  tsc_core #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC),
             .NS_INC(NS_INC), .GLITCH_WIN(GLITCH_WIN)) u_core (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .tod_sec_i(tod_sec_i),
    .adj_i(adj), .sec_o(sec_o), .ns_o(ns_o), .epoch_o(epoch_o),
    .glitch_o(glitch), .wrap_o(wrap)
  );

  assign cap_stb    = {egr_stb_i, ing_stb_i};
  assign cap_dly[0] = ing_dly_i;
  assign cap_dly[1] = egr_dly_i;

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    tsc_capture #(.SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC),
                  .DLY_W(DLY_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .stb_i(cap_stb[i]),
      .sec_i(sec_o), .ns_i(ns_o), .dly_i(cap_dly[i]),
      .vld_o(cap_vld[i]), .sec_o(cap_sec[i]), .ns_o(cap_ns[i])
    );
  end

  assign ing_vld_o = cap_vld[0];
  assign ing_sec_o = cap_sec[0];
  assign ing_ns_o  = cap_ns[0];
  assign egr_vld_o = cap_vld[1];
  assign egr_sec_o = cap_sec[1];
  assign egr_ns_o  = cap_ns[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_v_q <= 1'b0;
      evt_q   <= EV_NONE;
    end else begin
      evt_v_q <= glitch | step | wrap;
      if (glitch)    evt_q <= EV_GLITCH;
      else if (step) evt_q <= EV_STEP;
      else if (wrap) evt_q <= EV_WRAP;
      else           evt_q <= EV_NONE;
    end
  end

  assign evt_valid_o = evt_v_q;
  assign evt_code_o  = evt_q;
endmodule

// File: rtl/mono_slew_tod_chk.sv
module mono_slew_tod_chk #(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int NS_PER_SEC = 1_000_000_000,
  parameter int NS_INC     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             epoch_o,
  input logic [SEC_W-1:0] sec_o,
  input logic [NS_W-1:0]  ns_o,
  input logic             corr_ready_o,
  input logic             stable_i,
  input logic             evt_valid_o,
  input logic [1:0]       evt_code_o
);
  logic             ep_prev;
  logic [SEC_W-1:0] sec_prev;
  logic [NS_W-1:0]  ns_prev;
  logic [NS_W:0]    delta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_prev  <= 1'b0;
      sec_prev <= '0;
      ns_prev  <= '0;
    end else begin
      ep_prev  <= epoch_o;
      sec_prev <= sec_o;
      ns_prev  <= ns_o;
    end
  end

  assign delta = (ns_o >= ns_prev) ? ({1'b0, ns_o} - {1'b0, ns_prev})
               : ({1'b0, ns_o} + (NS_W+1)'(NS_PER_SEC) - {1'b0, ns_prev});

  assert_epoch_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ep_prev |-> epoch_o);
  assert_ns_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ns_o < NS_W'(NS_PER_SEC));
  assert_carry_on_roll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_prev && sec_o != sec_prev) |-> (ns_o < ns_prev));
  assert_ready_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    corr_ready_o |-> (epoch_o && stable_i));
  assert_code_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> (evt_code_o != 2'd0));
  assert_evt_after_epoch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> ep_prev);
  assert_bounded_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ep_prev |-> (delta >= (NS_W+1)'(NS_INC - 1) && delta <= (NS_W+1)'(NS_INC + 1)));
endmodule

bind mono_slew_tod mono_slew_tod_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC), .NS_INC(NS_INC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .epoch_o(epoch_o), .sec_o(sec_o), .ns_o(ns_o),
  .corr_ready_o(corr_ready_o), .stable_i(stable_i),
  .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o)
);

// File: tb/mono_slew_tod_tb.sv
module mono_slew_tod_tb;
  localparam int SEC_W = 4, NPS = 1000, INC = 8, SLEW_N = 4, OFS_W = 12;
  localparam int WIN = 16, DLY_W = 10, NS_W = $clog2(NPS);
  localparam int SEC_MAX = (1 << SEC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pps = 1'b0, stable = 1'b0, cvalid = 1'b0, cready;
  logic [SEC_W-1:0] tod = 4'd13;
  logic signed [OFS_W-1:0] cofs = '0;
  logic [OFS_W-1:0] cmax = 12'd100;
  logic [SEC_W-1:0] sec, isec, esec;
  logic [NS_W-1:0] ns, ins, ens;
  logic epoch, istb = 1'b0, estb = 1'b0, ivld, evld, ev;
  logic [DLY_W-1:0] idly = 10'd30, edly = 10'd995;
  logic [1:0] ecode;

  int vectors = 0, misses = 0;
  string cur = "R3";
  int m_sec, m_ns, m_pend, m_cnt, m_ev_c, m_is, m_in, m_es, m_en;
  bit m_epoch, m_ppsq, m_ev, m_iv, m_evd;

  always #4 clk = ~clk;

  mono_slew_tod #(.SEC_W(SEC_W), .NS_PER_SEC(NPS), .NS_INC(INC), .SLEW_N(SLEW_N),
    .OFS_W(OFS_W), .GLITCH_WIN(WIN), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_i(pps), .tod_sec_i(tod), .stable_i(stable),
    .corr_valid_i(cvalid), .corr_ready_o(cready), .corr_ofs_i(cofs),
    .max_corr_i(cmax), .sec_o(sec), .ns_o(ns), .epoch_o(epoch),
    .ing_stb_i(istb), .ing_dly_i(idly), .ing_vld_o(ivld), .ing_sec_o(isec),
    .ing_ns_o(ins), .egr_stb_i(estb), .egr_dly_i(edly), .egr_vld_o(evld),
    .egr_sec_o(esec), .egr_ns_o(ens), .evt_valid_o(ev), .evt_code_o(ecode));

  function automatic void chk(int act, int exp, string tag);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  function automatic bit m_ready();
    return m_epoch && stable && (m_pend == 0);
  endfunction

  function automatic void stamp(int s, int n, int d, output int os, output int on);
    on = n + d; os = s;
    if (on >= NPS) begin on -= NPS; os = (s + 1) & SEC_MAX; end
  endfunction

  task automatic model_step();
    bit rise, gl, st, wr;
    int adj, mag, sm;
    if (!rst_n) begin
      m_sec = 0; m_ns = 0; m_pend = 0; m_cnt = 0; m_epoch = 0; m_ppsq = 0;
      m_ev = 0; m_ev_c = 0; m_iv = 0; m_evd = 0;
      return;
    end
    rise = pps && !m_ppsq; gl = 0; st = 0; wr = 0; adj = 0;
    m_iv = istb; m_evd = estb;
    if (istb) stamp(m_sec, m_ns, int'(idly), m_is, m_in);
    if (estb) stamp(m_sec, m_ns, int'(edly), m_es, m_en);
    if (cvalid && m_ready()) begin
      mag = (int'(cofs) < 0) ? -int'(cofs) : int'(cofs);
      if (mag > int'(cmax)) st = 1; else m_pend = int'(cofs);
      m_cnt = 0;
    end else if (m_pend != 0) begin
      if (m_cnt == SLEW_N - 1) begin
        adj = (m_pend > 0) ? 1 : -1; m_pend -= adj; m_cnt = 0;
      end else m_cnt++;
    end
    if (!m_epoch) begin
      if (rise) begin m_sec = int'(tod); m_ns = 0; m_epoch = 1; end
    end else begin
      gl = rise && m_ns >= WIN && m_ns < NPS - WIN;
      sm = m_ns + INC + adj;
      if (sm >= NPS) begin
        sm -= NPS;
        if (m_sec == SEC_MAX) begin m_sec = 0; wr = 1; end else m_sec++;
      end
      m_ns = sm;
    end
    m_ev = gl || st || wr;
    m_ev_c = gl ? 2 : st ? 1 : wr ? 3 : 0;
    m_ppsq = pps;
  endtask

  task automatic compare();
    chk(int'(sec), m_sec, {cur, " sec"});
    chk(int'(ns), m_ns, {cur, " ns"});
    chk(int'(epoch), int'(m_epoch), "R2 epoch");
    chk(int'(cready), int'(m_ready()), "R5 ready");
    chk(int'(ev), int'(m_ev), "R6 R7 R8 R10 evt_valid");
    if (m_ev) chk(int'(ecode), m_ev_c, "R6 R7 R8 R10 evt_code");
    chk(int'(ivld), int'(m_iv), "R9 ing valid");
    chk(int'(evld), int'(m_evd), "R9 egr valid");
    if (m_iv) begin chk(int'(isec), m_is, "R9 ing sec"); chk(int'(ins), m_in, "R9 ing ns"); end
    if (m_evd) begin chk(int'(esec), m_es, "R9 egr sec"); chk(int'(ens), m_en, "R9 egr ns"); end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic send(int ofs);
    cofs = OFS_W'(ofs); cvalid = 1'b1;
    while (!m_ready()) cycle();
    cycle();
    cvalid = 1'b0;
  endtask

  task automatic pulse_pps();
    pps = 1'b1; cycle(); pps = 1'b0; cycle();
  endtask

  task automatic wait_mid();
    while (!(m_ns >= 300 && m_ns < 600)) cycle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    run(3);
    // R1: reset state
    chk(int'(sec), 0, "R1 sec"); chk(int'(ns), 0, "R1 ns");
    chk(int'(epoch), 0, "R1 epoch"); chk(int'(cready), 0, "R1 ready");
    chk(int'(ev), 0, "R1 evt"); chk(int'(ivld | evld), 0, "R1 capture");
    rst_n = 1'b1;
    cur = "R2"; stable = 1'b1;
    run(5);                         // counter idle before epoch, ready low
    pulse_pps();                    // R2 epoch load
    tod = 4'd2;
    run(30);
    cur = "R3"; run(150);           // R3 rollover with carry, no event
    cur = "R5"; stable = 1'b0; cofs = 12'sd5; cvalid = 1'b1;
    run(12);                        // R5 held while gate low, no effect
    cur = "R4"; stable = 1'b1;
    send(5); cofs = -12'sd7; cvalid = 1'b1; // R5 back-pressure during slew
    send(-7); run(40);
    cur = "R6"; send(200); send(-101); run(5);
    send(100); run(420);            // R6 boundary magnitude accepted
    send(-100); run(420);
    cur = "R7"; wait_mid(); pulse_pps();   // glitch
    while (m_ns < NPS - WIN) cycle();
    pulse_pps();                    // on boundary, no event
    run(3); pulse_pps();            // just after boundary
    cur = "R10"; wait_mid();
    pps = 1'b1; cofs = 12'sd500; cvalid = 1'b1; cycle();
    pps = 1'b0; cvalid = 1'b0; run(3);
    cur = "R9";
    istb = 1'b1; cycle(); istb = 1'b0; run(7);
    estb = 1'b1; cycle(); estb = 1'b0; run(5);
    for (int k = 0; k < 40; k++) begin
      istb = k[0]; estb = k[1] | k[2];
      run(1 + (k % 5) * 9);
    end
    istb = 1'b0; estb = 1'b0;
    cur = "R8";
    while (!(m_sec == SEC_MAX && m_ns > NPS - 40)) cycle();
    istb = 1'b1; estb = 1'b1; run(8); istb = 1'b0; estb = 1'b0;
    run(300);
    summary();
  end
endmodule